// File: doc/BRIEF.md
# I2C Target Register Port

This block is an I2C target that lets an external bus controller read and write a bank of 8-bit configuration registers held inside it. SCL and SDA are oversampled by a faster system clock through a two-flop synchronizer, and all bus activity is decoded from the edges of the synchronized lines. The block only ever pulls SDA low, through a drive-low enable, and it changes that enable only while SCL is low.

A write transfer carries the target address, then a pointer byte, then any number of data bytes. Bit 7 of the pointer byte turns on auto-increment and the low bits pick the register. A read transfer has no pointer of its own. It starts at the register the stored pointer selects, and that pointer is normally set by a write that the controller ends with STOP right after the pointer byte is acknowledged. The rest of the chip reads the registers through a combinational parallel port.

Top module: `i2c_reg_port`

## Requirements
- R1: A START (SDA falling while SCL is high) at any point, including a repeated START in the middle of a transfer, restarts address reception. A STOP (SDA rising while SCL is high) returns the block to idle, and bits clocked after a STOP with no new START get no acknowledge.
- R2: The first byte after START holds the address in bits 7:1 and the direction in bit 0 (1 = read, 0 = write). Only address 7'b1001010 (write byte 0x94, read byte 0x95) is acknowledged, by pulling SDA low during the ninth SCL high phase. Any other address leaves SDA released.
- R3: In a write, the byte after the address is the pointer: bit 7 is the auto-increment flag and bits 6:0 are the register index. Each complete data byte is stored in the register the pointer selects and is acknowledged.
- R4: With the auto-increment flag set, each further data byte of a write goes to the next register up.
- R5: With the auto-increment flag clear, the pointer stays put, so repeated data bytes in a write, or repeated bytes in a read, all use the same register.
- R6: A read sends, MSB first, the register the stored pointer selects. The pointer survives STOP and the next START.
- R7: In a read, an acknowledge from the controller (SDA low in the ninth clock) requests the next byte. With auto-increment set, the pointer then moves up by one, so the pointer only advances on an acknowledge. A NACK ends the read, and SDA stays released until the next START or STOP.
- R8: The pointer wraps from 127 to 0 on increment, in both writes and reads.
- R9: A byte that was only partly received when a START or STOP arrives is discarded and changes no register.
- R10: The SDA drive-low enable changes only while the synchronized SCL is low.
- R11: After reset every register reads 0 and SDA is released. The parallel port returns the register selected by its index input combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, faster than SCL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line from the pad |
| sda_i | input | 1 | Bus data line from the pad |
| sda_oe_o | output | 1 | Pulls SDA low when high |
| cfg_addr_i | input | 7 | Register index for the parallel read port |
| cfg_data_o | output | 8 | Register contents at cfg_addr_i |

## Verification
Every one of the 128 write-direction addresses is offered, and only one of them must draw an acknowledge. This separates a correct address compare from a partial or inverted one. A single auto-increment write fills all 128 registers with values computed from their index, and the parallel port then reads every register back, which exposes an index error or a skipped increment anywhere in the space. Short transfers then test the pointer. They cover a pointer with the increment flag clear, a wrap at 127 in both directions, a read that ends on a NACK followed by a read that must resume at the register where the last acknowledge left the pointer, and bytes cut short by a STOP or a repeated START, which must leave their target registers unchanged.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_PTR,
    ST_PACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK,
    ST_HOLD
  } tgt_state_e;
endpackage

// File: rtl/i2c_reg_sync.sv
module i2c_reg_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s_o,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] scl_sr, sda_sr;
  logic         scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[MSB-1:0], scl_i};
      sda_sr <= {sda_sr[MSB-1:0], sda_i};
      scl_d  <= scl_sr[MSB];
      sda_d  <= sda_sr[MSB];
    end
  end

  assign scl_s_o    = scl_sr[MSB];
  assign sda_s_o    = sda_sr[MSB];
  assign scl_rise_o = scl_s_o & ~scl_d;
  assign scl_fall_o = ~scl_s_o & scl_d;
  // SDA edge while SCL high on both samples
  assign start_o    = scl_s_o & scl_d & sda_d & ~sda_s_o;
  assign stop_o     = scl_s_o & scl_d & ~sda_d & sda_s_o;
endmodule

// File: rtl/i2c_reg_file.sv
module i2c_reg_file #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  output logic [DW-1:0] rdata_a_o,
  input  logic [AW-1:0] raddr_b_i,
  output logic [DW-1:0] rdata_b_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];
endmodule

// File: rtl/i2c_reg_port.sv
module i2c_reg_port
  import i2c_reg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'b1001010,
  parameter int         AW          = 7,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                scl_i,
  input  logic                sda_i,
  output logic                sda_oe_o,
  input  logic [AW-1:0]       cfg_addr_i,
  output logic [BYTE_W-1:0]   cfg_data_o
);
  localparam int INC_BIT = BYTE_W - 1;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_reg_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s_o   (scl_s),
    .sda_s_o   (sda_s),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_det),
    .stop_o    (stop_det)
  );

  tgt_state_e        state;
  logic [3:0]        bit_cnt;
  logic [BYTE_W-1:0] shreg, tx;
  logic [AW-1:0]     ptr, rd_ptr;
  logic              auto_inc, is_read, nack_q;
  logic              reg_we;
  logic [BYTE_W-1:0] rd_data;
  logic              byte_in_done;

  assign byte_in_done = scl_fall && (bit_cnt == 4'd8);
  assign reg_we = (state == ST_WDATA) && byte_in_done && !start_det && !stop_det;
  // next read byte comes from ptr+1 once the controller acks with increment on
  assign rd_ptr = (state == ST_RACK && auto_inc) ? ptr + AW'(1) : ptr;

  i2c_reg_file #(.AW(AW), .DW(BYTE_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we),
    .waddr_i  (ptr),
    .wdata_i  (shreg),
    .raddr_a_i(rd_ptr),
    .rdata_a_o(rd_data),
    .raddr_b_i(cfg_addr_i),
    .rdata_b_o(cfg_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      tx       <= '0;
      sda_oe_o <= 1'b0;
      ptr      <= '0;
      auto_inc <= 1'b0;
      is_read  <= 1'b0;
      nack_q   <= 1'b1;
    end else if (start_det) begin
      state    <= ST_ADDR;
      bit_cnt  <= '0;
      sda_oe_o <= 1'b0;
    end else if (stop_det) begin
      state    <= ST_IDLE;
      sda_oe_o <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR, ST_PTR, ST_WDATA: begin
          if (scl_rise) begin
            shreg   <= {shreg[BYTE_W-2:0], sda_s};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (byte_in_done) begin
            bit_cnt <= '0;
            if (state == ST_ADDR) begin
              if (shreg[BYTE_W-1:1] == DEV_ADDR) begin
                is_read  <= shreg[0];
                state    <= ST_AACK;
                sda_oe_o <= 1'b1;
              end else begin
                state <= ST_IDLE;
              end
            end else if (state == ST_PTR) begin
              ptr      <= shreg[AW-1:0];
              auto_inc <= shreg[INC_BIT];
              state    <= ST_PACK;
              sda_oe_o <= 1'b1;
            end else begin
              if (auto_inc) ptr <= ptr + AW'(1);
              state    <= ST_WACK;
              sda_oe_o <= 1'b1;
            end
          end
        end
        ST_AACK, ST_PACK, ST_WACK: begin
          if (scl_fall) begin
            bit_cnt <= '0;
            if (state == ST_AACK && is_read) begin
              state    <= ST_RDATA;
              tx       <= rd_data;
              sda_oe_o <= ~rd_data[BYTE_W-1];
            end else begin
              state    <= (state == ST_AACK) ? ST_PTR : ST_WDATA;
              sda_oe_o <= 1'b0;
            end
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (bit_cnt == 4'd7) begin
              state    <= ST_RACK;
              sda_oe_o <= 1'b0;
              bit_cnt  <= '0;
            end else begin
              tx       <= {tx[BYTE_W-2:0], 1'b0};
              sda_oe_o <= ~tx[BYTE_W-2];
              bit_cnt  <= bit_cnt + 4'd1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            nack_q <= sda_s;
          end else if (scl_fall) begin
            if (!nack_q) begin
              ptr      <= rd_ptr;
              tx       <= rd_data;
              sda_oe_o <= ~rd_data[BYTE_W-1];
              state    <= ST_RDATA;
            end else begin
              state <= ST_HOLD;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_reg_port_chk.sv
module i2c_reg_port_chk
  import i2c_reg_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_s,
  input logic       sda_oe_o,
  input logic       start_det,
  input logic       stop_det,
  input tgt_state_e state,
  input logic       reg_we
);
  AST_OE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o)) && !$past(start_det) && !$past(stop_det) |-> !$past(scl_s)); // R10

  AST_START_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> (state == ST_ADDR) && !sda_oe_o); // R1

  AST_STOP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> (state == ST_IDLE) && !sda_oe_o); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE || state == ST_HOLD) |-> !sda_oe_o); // R2

  AST_WRITE_ACKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we |=> (state == ST_WACK) && sda_oe_o); // R3
endmodule

bind i2c_reg_port i2c_reg_port_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .scl_s    (scl_s),
  .sda_oe_o (sda_oe_o),
  .start_det(start_det),
  .stop_det (stop_det),
  .state    (state),
  .reg_we   (reg_we)
);

// File: tb/test_i2c_reg_port.sv
module test_i2c_reg_port;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 6;
  localparam int WATCHDOG = 190000;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_oe_o;
  logic       sda_line;
  logic [6:0] cfg_addr_i = '0;
  logic [7:0] cfg_data_o;

  int checks = 0;
  int errors = 0;
  int r10_viol = 0;
  int exp_mem [128];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sda_line = sda_m & ~sda_oe_o;

  i2c_reg_port i_i2c_reg_port (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .scl_i     (scl_m),
    .sda_i     (sda_line),
    .sda_oe_o  (sda_oe_o),
    .cfg_addr_i(cfg_addr_i),
    .cfg_data_o(cfg_data_o)
  );

  // R10 monitor: enable must not move while SCL is high
  logic prev_scl = 1'b1, prev_oe = 1'b0;
  always @(negedge clk) begin
    if (rst_ni && scl_m && prev_scl && (sda_oe_o != prev_oe)) r10_viol++;
    prev_scl <= scl_m;
    prev_oe  <= sda_oe_o;
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_q();
    scl_m = 1'b1; wait_q();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b1; wait_q();
    sda_m = 1'b1; wait_q();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b;    wait_q();
    scl_m = 1'b1; wait_q(); wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wait_q();
    scl_m = 1'b1; wait_q();
    b = sda_line; wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic put_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic get_byte(output logic [7:0] d, input logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    put_bit(~ack);
  endtask

  // aborted write that only loads the pointer
  task automatic set_ptr(input logic [7:0] p);
    logic ack;
    bus_start();
    put_byte(8'h94, ack);
    put_byte(p, ack);
    check_eq("R3 pointer byte ack", int'(ack), 1);
    bus_stop();
  endtask

  task automatic reg_check(input string req, input int idx);
    cfg_addr_i = 7'(idx);
    @(negedge clk);
    check_eq(req, int'(cfg_data_o), exp_mem[idx]);
  endtask

  initial begin
    logic       ack, b;
    logic [7:0] d;

    for (int i = 0; i < 128; i++) exp_mem[i] = 0;
    repeat (5) @(negedge clk);
    check_eq("R11 reset sda released", int'(sda_oe_o), 0);
    reg_check("R11 reset reg 0", 0);
    reg_check("R11 reset reg 64", 64);
    reg_check("R11 reset reg 127", 127);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);

    // R2: address sweep, write direction
    for (int a = 0; a < 128; a++) begin
      bus_start();
      put_byte({7'(a), 1'b0}, ack);
      check_eq("R2 address ack", int'(ack), (a == 'h4A) ? 1 : 0);
      bus_stop();
    end

    // R3/R4: fill all registers in one auto-increment write
    bus_start();
    put_byte(8'h94, ack);
    put_byte(8'h80, ack);
    for (int i = 0; i < 128; i++) begin
      d = 8'((i * 37 + 5) & 8'hFF);
      put_byte(d, ack);
      check_eq("R3 data ack", int'(ack), 1);
      exp_mem[i] = int'(d);
    end
    bus_stop();
    for (int i = 0; i < 128; i++) reg_check("R4 R11 sweep readback", i);

    // R8: write wrap 127 -> 0
    bus_start();
    put_byte(8'h94, ack);
    put_byte(8'h80 | 8'd126, ack);
    put_byte(8'hA1, ack); exp_mem[126] = 'hA1;
    put_byte(8'hA2, ack); exp_mem[127] = 'hA2;
    put_byte(8'hA3, ack); exp_mem[0]   = 'hA3;
    bus_stop();
    reg_check("R8 wrap reg 126", 126);
    reg_check("R8 wrap reg 127", 127);
    reg_check("R8 wrap reg 0", 0);
    reg_check("R8 wrap reg 1", 1);

    // R5: no increment, same register
    bus_start();
    put_byte(8'h94, ack);
    put_byte(8'h05, ack);
    put_byte(8'h11, ack);
    put_byte(8'h22, ack);
    put_byte(8'h33, ack);
    exp_mem[5] = 'h33;
    bus_stop();
    reg_check("R5 reg 5 last byte", 5);
    reg_check("R5 reg 6 untouched", 6);

    // R6/R7: read four bytes from pointer 10
    set_ptr(8'h80 | 8'd10);
    bus_start();
    put_byte(8'h95, ack);
    check_eq("R2 read address ack", int'(ack), 1);
    for (int i = 0; i < 4; i++) begin
      get_byte(d, i < 3);
      check_eq("R6 R7 read data", int'(d), exp_mem[10 + i]);
    end
    get_bit(b);
    check_eq("R7 released after NACK", int'(b), 1);
    check_eq("R7 enable low after NACK", int'(sda_oe_o), 0);
    bus_stop();

    // R6: pointer kept across STOP/START; it sits at 13 after three acks
    bus_start();
    put_byte(8'h95, ack);
    get_byte(d, 1'b0);
    check_eq("R6 R7 pointer kept", int'(d), exp_mem[13]);
    bus_stop();

    // R5: read without increment
    set_ptr(8'd20);
    bus_start();
    put_byte(8'h95, ack);
    for (int i = 0; i < 3; i++) begin
      get_byte(d, i < 2);
      check_eq("R5 read same register", int'(d), exp_mem[20]);
    end
    bus_stop();

    // R8: read wrap
    set_ptr(8'h80 | 8'd127);
    bus_start();
    put_byte(8'h95, ack);
    get_byte(d, 1'b1);
    check_eq("R8 read reg 127", int'(d), exp_mem[127]);
    get_byte(d, 1'b0);
    check_eq("R8 read wraps to 0", int'(d), exp_mem[0]);
    bus_stop();

    // R9: partial byte cut by STOP
    bus_start();
    put_byte(8'h94, ack);
    put_byte(8'h80 | 8'd40, ack);
    put_byte(8'h5A, ack); exp_mem[40] = 'h5A;
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    bus_stop();
    reg_check("R9 full byte kept", 40);
    reg_check("R9 partial byte dropped by STOP", 41);

    // R9/R1: partial byte cut by repeated START
    bus_start();
    put_byte(8'h94, ack);
    put_byte(8'h80 | 8'd50, ack);
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    bus_start();
    put_byte(8'h94, ack);
    check_eq("R1 repeated start address ack", int'(ack), 1);
    put_byte(8'h80 | 8'd60, ack);
    put_byte(8'h77, ack); exp_mem[60] = 'h77;
    bus_stop();
    reg_check("R9 partial byte dropped by START", 50);
    reg_check("R1 write after repeated start", 60);

    // R1: no START after STOP -> no response
    put_byte(8'h94, ack);
    check_eq("R1 no ack without START", int'(ack), 0);
    bus_stop();

    check_eq("R10 enable moved with SCL high", r10_viol, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule